// File: doc/BRIEF.md
# Windowed Local Memory Bridge

This block lets a host with a small register aperture reach an on-card local SRAM that is larger than the aperture. The host first writes a base register. Accesses that then land in a fixed 2 KB window of the register space are redirected to local memory. The local address is taken from the upper bits of the base register, and the offset within the window supplies the lower bits. The low window-size bits of the base register play no part in a window access.

A second register provides single-word indirect access. A read or write of this data register goes to the word named by the full base register value. The base then moves forward by one word, so a stream of words can be moved through a single register. A transfer through the window that goes past a 2 KB boundary needs the host to reprogram the base register at that boundary.

All accesses are whole 32-bit words. Local memory is a synchronous single-port memory whose depth is set by a parameter. The default is small enough for simulation, and a deployment sets `LOCAL_AW` to 19 for 512 KB. Address bits above the memory size are ignored, so the address space wraps.

Top module: `win_mem_bridge`

## Requirements
- R1: After synchronous active-high reset, `host_rvalid` is low and the base register reads as 0.
- R2: A write to register offset 0x068 loads the 32-bit base register, and a read of 0x068 returns all 32 bits as written.
- R3: An access at host offset 0x800 + k (k from 0 to 0x7FC, word aligned) reaches local byte address (base with its low 11 bits cleared) + k, and base bits 10:0 have no effect.
- R4: A read request is answered exactly one cycle later: `host_rvalid` is high for one cycle and `host_rdata` holds the addressed value in that cycle.
- R5: A read or write at offset 0x06C accesses local word base[LOCAL_AW-1:2], and afterwards the base register has increased by 4.
- R6: A base write takes effect on the access in the very next cycle, and back-to-back requests need no idle cycles.
- R7: Local byte address bits at and above `LOCAL_AW` are ignored, so addresses alias modulo 2^LOCAL_AW (default 8 KB).
- R8: Indirect accesses that run over a 2 KB boundary continue into the next window, and window accesses using different bases reach distinct local words.
- R9: Offsets other than 0x068, 0x06C and the window read as 0. Writes to them change neither memory nor the base register.
- R10: A write request never produces `host_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Access request, one per cycle at most |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | HOST_AW (12) | Byte offset in the register space |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read data valid, one cycle after a read request |

## Verification
The bench programs a base with nonzero low bits and then uses the window. A bridge that did not mask those bits would land on the wrong word and return stale data. It checks the base value after runs of indirect accesses, including a run that crosses the 0x7FC to 0x800 boundary. A missing or double increment, or an increment applied only on writes, shows up as a wrong base value or misplaced words. Base writes directly followed by window accesses would expose a one-cycle lag in address translation. A base above the memory size must alias onto an earlier word, and a design that kept too many address bits would miss it. Unmapped writes followed by base and data reads would catch stray decoding.

// File: rtl/win_mem_pkg.sv
package win_mem_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_BASE = 2'd1,
    SEL_DATA = 2'd2,
    SEL_WIN  = 2'd3
  } win_sel_e;

  localparam int unsigned WORD_W = 32;
endpackage

// File: rtl/win_mem_decode.sv
module win_mem_decode
  import win_mem_pkg::*;
#(
  parameter int unsigned HOST_AW   = 12,
  parameter int unsigned LOCAL_AW  = 13,
  parameter int unsigned WIN_BYTES = 2048,
  parameter logic [HOST_AW-1:0] BASE_OFS = 12'h068,
  parameter logic [HOST_AW-1:0] DATA_OFS = 12'h06C,
  parameter logic [HOST_AW-1:0] WIN_OFS  = 12'h800
) (
  input  logic                 host_req,
  input  logic                 host_we,
  input  logic [HOST_AW-1:0]   host_addr,
  input  logic [WORD_W-1:0]    base_q,
  output win_sel_e             sel,
  output logic                 mem_en,
  output logic                 mem_we,
  output logic [LOCAL_AW-3:0]  mem_addr,
  output logic                 base_wr,
  output logic                 base_inc
);
  localparam int unsigned WIN_AW = $clog2(WIN_BYTES);
  localparam int unsigned WW     = WIN_AW - 2;

  logic win_hit;
  logic [LOCAL_AW-3:0] win_addr;
  logic [LOCAL_AW-3:0] ind_addr;

  assign win_hit  = (host_addr[HOST_AW-1:WIN_AW] == WIN_OFS[HOST_AW-1:WIN_AW]);
  assign win_addr = {base_q[LOCAL_AW-1:WIN_AW], host_addr[WIN_AW-1:2]};
  assign ind_addr = base_q[LOCAL_AW-1:2];

  always_comb begin
    sel = SEL_NONE;
    if (host_req) begin
      if (win_hit)                       sel = SEL_WIN;
      else if (host_addr == BASE_OFS)    sel = SEL_BASE;
      else if (host_addr == DATA_OFS)    sel = SEL_DATA;
    end
  end

  assign mem_en   = (sel == SEL_WIN) || (sel == SEL_DATA);
  assign mem_we   = mem_en && host_we;
  assign mem_addr = (sel == SEL_WIN) ? win_addr : ind_addr;
  assign base_wr  = (sel == SEL_BASE) && host_we;
  assign base_inc = (sel == SEL_DATA);

  logic unused_bits;
  assign unused_bits = ^{host_addr[1:0], base_q[WORD_W-1:LOCAL_AW], base_q[1:0], WW[0]};
endmodule

// File: rtl/win_mem_base.sv
module win_mem_base
  import win_mem_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              inc,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (wr)   q <= wdata;
    else if (inc)  q <= q + 32'd4;
  end

  // R5: indirect access advances the base by one word
  p_base_step_r5: assert property (@(posedge clk) disable iff (rst)
    (inc && !wr) |=> (q == $past(q) + 32'd4));

  // R9: base untouched without a base write or indirect access
  p_base_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!inc && !wr) |=> $stable(q));
endmodule

// File: rtl/win_mem_sram.sv
module win_mem_sram
  import win_mem_pkg::*;
#(
  parameter int unsigned AW = 11
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] q
);
  localparam int unsigned DEPTH = 2 ** AW;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      q <= mem[addr];
    end
  end
endmodule

// File: rtl/win_mem_bridge.sv
module win_mem_bridge
  import win_mem_pkg::*;
#(
  parameter int unsigned HOST_AW   = 12,
  parameter int unsigned LOCAL_AW  = 13,
  parameter int unsigned WIN_BYTES = 2048
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_req,
  input  logic               host_we,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [31:0]        host_wdata,
  output logic [31:0]        host_rdata,
  output logic               host_rvalid
);
  localparam int unsigned MW     = LOCAL_AW - 2;
  localparam int unsigned WIN_AW = $clog2(WIN_BYTES);
  localparam int unsigned WW     = WIN_AW - 2;

  win_sel_e          sel;
  logic              mem_en, mem_we, base_wr, base_inc;
  logic [MW-1:0]     mem_addr;
  logic [WORD_W-1:0] base_q, sram_q;

  logic              rvalid_q, from_mem_q;
  logic [WORD_W-1:0] hold_q;

  win_mem_decode #(
    .HOST_AW(HOST_AW), .LOCAL_AW(LOCAL_AW), .WIN_BYTES(WIN_BYTES)
  ) u_decode (
    .host_req (host_req),
    .host_we  (host_we),
    .host_addr(host_addr),
    .base_q   (base_q),
    .sel      (sel),
    .mem_en   (mem_en),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .base_wr  (base_wr),
    .base_inc (base_inc)
  );

  win_mem_base u_base (
    .clk  (clk),
    .rst  (rst),
    .wr   (base_wr),
    .inc  (base_inc),
    .wdata(host_wdata),
    .q    (base_q)
  );

  win_mem_sram #(.AW(MW)) u_sram (
    .clk  (clk),
    .en   (mem_en),
    .we   (mem_we),
    .addr (mem_addr),
    .wdata(host_wdata),
    .q    (sram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid_q   <= 1'b0;
      from_mem_q <= 1'b0;
      hold_q     <= '0;
    end else begin
      rvalid_q   <= host_req && !host_we;
      from_mem_q <= mem_en && !host_we;
      hold_q     <= (sel == SEL_BASE) ? base_q : '0;
    end
  end

  assign host_rvalid = rvalid_q;
  assign host_rdata  = from_mem_q ? sram_q : hold_q;

  // R4: a read is answered in the following cycle
  p_read_answer_r4: assert property (@(posedge clk) disable iff (rst)
    (host_req && !host_we) |=> host_rvalid);

  // R10: no read-valid without a read one cycle earlier
  p_no_spurious_r10: assert property (@(posedge clk) disable iff (rst)
    !(host_req && !host_we) |=> !host_rvalid);

  // R3: window offset supplies the low word-address bits
  p_win_low_r3: assert property (@(posedge clk) disable iff (rst)
    (sel == SEL_WIN) |-> (mem_addr[WW-1:0] == host_addr[WIN_AW-1:2]));

  // R3: base supplies the high bits, its low window bits dropped
  p_win_high_r3: assert property (@(posedge clk) disable iff (rst)
    (sel == SEL_WIN) |-> (mem_addr[MW-1:WW] == base_q[LOCAL_AW-1:WIN_AW]));
endmodule

// File: tb/win_mem_bridge_bench.sv
module win_mem_bridge_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_req = 1'b0;
  logic        host_we = 1'b0;
  logic [11:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        host_rvalid;

  int tests = 0;
  int fails = 0;
  logic  [31:0] exp_q [$];
  string        tag_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  win_mem_bridge u_win_mem_bridge (
    .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_rvalid(host_rvalid)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    host_req = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    host_req = 1'b1; host_we = 1'b0; host_addr = a; host_wdata = '0;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
  endtask

  task automatic idle();
    host_req = 1'b0; host_we = 1'b0;
    @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && host_rvalid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R10 rvalid without read", {31'd0, host_rvalid}, 32'd0);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(host_rdata === e, t, host_rdata, e);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(host_rvalid === 1'b0, "R1 rvalid after reset", {31'd0, host_rvalid}, 32'd0);
    rd(12'h068, 32'h0, "R1 base after reset");

    // R2: full base value readable
    wr(12'h068, 32'h0000_0ABC);
    rd(12'h068, 32'h0000_0ABC, "R2 base readback");

    // R3: low base bits ignored; 0x800 window + 4 -> local 0x804
    wr(12'h804, 32'hAAAA_0001);
    // R5: indirect read of 0x804, then base advanced
    wr(12'h068, 32'h0000_0804);
    rd(12'h06C, 32'hAAAA_0001, "R5 indirect read at base");
    rd(12'h068, 32'h0000_0808, "R5 base incremented after read");
    // R4: window read one cycle latency
    wr(12'h068, 32'h0000_0800);
    rd(12'h804, 32'hAAAA_0001, "R4 window read data");
    idle();

    // R6: base writes take effect immediately, back to back
    wr(12'h068, 32'h0000_1000);
    wr(12'h800, 32'hBBBB_0002);
    wr(12'h068, 32'h0000_0000);
    wr(12'h800, 32'hCCCC_0003);
    wr(12'h068, 32'h0000_1000);
    rd(12'h800, 32'hBBBB_0002, "R6 new base used next cycle (0x1000)");
    wr(12'h068, 32'h0000_0000);
    rd(12'h800, 32'hCCCC_0003, "R6 new base used next cycle (0x0)");

    // R5: indirect writes stream through ascending words
    wr(12'h068, 32'h0000_0200);
    wr(12'h06C, 32'hD000_0000);
    wr(12'h06C, 32'hD000_0001);
    wr(12'h06C, 32'hD000_0002);
    rd(12'h068, 32'h0000_020C, "R5 base after three indirect writes");
    wr(12'h068, 32'h0000_0000);
    rd(12'hA00, 32'hD000_0000, "R5 indirect word 0");
    rd(12'hA04, 32'hD000_0001, "R5 indirect word 1");
    rd(12'hA08, 32'hD000_0002, "R5 indirect word 2");

    // R7: addresses wrap at 8 KB: 0x3000 aliases 0x1000
    wr(12'h068, 32'h0000_3000);
    rd(12'h800, 32'hBBBB_0002, "R7 aliasing above memory size");
    rd(12'h068, 32'h0000_3000, "R7 base keeps upper bits");

    // R8: indirect run over the 2 KB boundary
    wr(12'h068, 32'h0000_07FC);
    wr(12'h06C, 32'hEEEE_0000);
    wr(12'h06C, 32'hEEEE_0001);
    wr(12'h068, 32'h0000_0000);
    rd(12'hFFC, 32'hEEEE_0000, "R8 last word of window 0");
    wr(12'h068, 32'h0000_0800);
    rd(12'h800, 32'hEEEE_0001, "R8 first word of window 1");
    wr(12'h068, 32'h0000_07FC);
    rd(12'h800, 32'hCCCC_0003, "R8 base 0x7FC selects window 0");

    // R9/R10: unmapped offsets
    wr(12'h068, 32'h0000_0200);
    wr(12'h070, 32'hDEAD_BEEF);
    check(host_rvalid === 1'b0, "R10 no rvalid after write", {31'd0, host_rvalid}, 32'd0);
    wr(12'h000, 32'hDEAD_BEEF);
    rd(12'h070, 32'h0, "R9 unmapped reads zero");
    rd(12'h068, 32'h0000_0200, "R9 base untouched by unmapped write");
    rd(12'h06C, 32'hD000_0000, "R9 memory untouched by unmapped write");
    idle();
    idle();

    check(exp_q.size() == 0, "R4 all reads answered", exp_q.size(), 32'd0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    check(1'b0, "watchdog expired", 32'd0, 32'd1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule